// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of which power mode a microcontroller is in and works out the next one. There are five modes: high-speed, subactive, subsleep, watch and hardware standby. In subactive mode the CPU runs from the slow subclock. The block takes these inputs:

- a one-cycle sleep-instruction strobe;
- an interrupt request;
- two reset pins;
- an active-low standby pin;
- four configuration bits: standby-select, direct-transfer, low-speed-on and prescaler-select;
- the system clock divider field.

On a sleep strobe, the next mode depends on the four configuration bits as they stand in that cycle.

The block drives:

- the current mode code;
- a CPU clock-select (main clock or subclock);
- a CPU-halt indication;
- a clock enable for each peripheral group;
- the main oscillator enable.

It also gives three one-cycle pulses, each registered together with the mode update:

- a request that matched no transition;
- a refused subactive entry caused by a nonzero divider;
- a demand that the owner of the divider field clear it on the direct return to high-speed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The mode codes are high-speed=0, subactive=1, subsleep=2, watch=3 and hardware standby=4. While `rst_n` is low, and after it is released, the block is in high-speed mode. All clock enables and `osc_en` are high and no pulse output is set.
- R2: In high-speed mode, a sleep strobe with standby-select, direct-transfer, low-speed-on and prescaler-select all 1 and `cfg_div` zero moves the block to subactive on the next clock.
- R3: The same strobe with a nonzero `cfg_div` keeps the block in high-speed mode and raises `cfg_err` for one cycle.
- R4: In subactive mode, a sleep strobe with standby-select=1, direct-transfer=0 and prescaler-select=1 moves the block to watch mode.
- R5: In subactive mode, a sleep strobe with standby-select=0, low-speed-on=1 and prescaler-select=1 moves the block to subsleep mode.
- R6: In subactive mode, a sleep strobe with standby-select=1, direct-transfer=1, low-speed-on=0 and prescaler-select=1 moves the block to high-speed mode and pulses `div_clr` for one cycle.
- R7: In watch mode, an interrupt moves the block to subactive mode when low-speed-on=1. With low-speed-on=0 the mode is unchanged.
- R8: In subsleep mode, any interrupt moves the block to subactive mode.
- R9: `stby_n` low forces hardware standby from any mode, ahead of every other input. Hardware standby is left only by a reset pin while `stby_n` is high. Sleep strobes and interrupts there have no effect.
- R10: With `stby_n` high, either reset pin moves the block to high-speed mode from any mode.
- R11: In high-speed or subactive mode, a sleep strobe that matches no transition leaves the mode unchanged and pulses `illegal_req` for one cycle.
- R12: Clock enables depend on the mode:
  - high-speed: every group enable and `osc_en` are high;
  - subactive, subsleep and watch: only groups 0 (bus controller), 1 (timers), 2 (watchdog 0) and 3 (watchdog 1) stay enabled, and `osc_en` is low;
  - hardware standby: all enables are low.
- R13: `cpu_sub_clk` is high in subactive, subsleep and watch. `cpu_halt` is high in subsleep, watch and hardware standby.
- R14: Interrupts in high-speed or subactive mode have no effect, and so do sleep strobes in subsleep or watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe |
| irq_req | input | 1 | Interrupt request |
| rst_pin_a | input | 1 | First reset pin, active high |
| rst_pin_b | input | 1 | Second reset pin, active high |
| stby_n | input | 1 | Standby pin, active low |
| cfg_ssel | input | 1 | Standby-select bit |
| cfg_dtr | input | 1 | Direct-transfer bit |
| cfg_lspd | input | 1 | Low-speed-on bit |
| cfg_psel | input | 1 | Subclock prescaler-select bit |
| cfg_div | input | DIV_W | System clock divider field |
| mode_o | output | 3 | Current mode code |
| cpu_sub_clk | output | 1 | CPU clock-select: 1 selects the subclock |
| cpu_halt | output | 1 | CPU halted |
| clk_en | output | NGRP | Per-peripheral-group clock enables |
| osc_en | output | 1 | Main system oscillator enable |
| illegal_req | output | 1 | Unmatched sleep request pulse |
| cfg_err | output | 1 | Refused subactive entry pulse |
| div_clr | output | 1 | Divider-field clear demand pulse |

## Verification
The properties assume that `stby_n`, the reset pins and the configuration bits are synchronous to `clk`. They also assume that the configuration bits are stable in any cycle that carries a sleep strobe or an interrupt. The bench changes every input only on the falling edge, so each rising edge sees settled levels. It holds each strobe for exactly one cycle. Before each swept strobe, it brings the block to a known mode through a reset pin.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [2:0] {
    PM_HIGH     = 3'd0,
    PM_SUBACT   = 3'd1,
    PM_SUBSLEEP = 3'd2,
    PM_WATCH    = 3'd3,
    PM_HWSTBY   = 3'd4
  } pm_mode_e;

  typedef struct packed {
    logic ssel;
    logic dtr;
    logic lspd;
    logic psel;
  } pm_cfg_t;

  typedef struct packed {
    pm_mode_e mode;
    logic     illegal;
    logic     cfg_err;
    logic     div_clr;
  } pm_dec_t;

endpackage

// File: rtl/pm_rstsync.sv
module pm_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  // Assert asynchronously, release after STAGES rising edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/pm_next.sv
module pm_next
  import pm_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  pm_mode_e         cur,
  input  logic             sleep,
  input  logic             irq,
  input  pm_cfg_t          cfg,
  input  logic [DIV_W-1:0] div,
  input  logic             rst_pin,
  input  logic             stby_n,
  output pm_dec_t          nxt
);
  logic all_set;
  assign all_set = cfg.ssel & cfg.dtr & cfg.lspd & cfg.psel;

  always_comb begin
    nxt.mode    = cur;
    nxt.illegal = 1'b0;
    nxt.cfg_err = 1'b0;
    nxt.div_clr = 1'b0;
    if (!stby_n) begin
      nxt.mode = PM_HWSTBY;
    end else if (rst_pin) begin
      nxt.mode = PM_HIGH;
    end else begin
      case (cur)
        PM_HIGH: begin
          if (sleep) begin
            if (all_set) begin
              if (div == '0) nxt.mode    = PM_SUBACT;
              else           nxt.cfg_err = 1'b1;
            end else begin
              nxt.illegal = 1'b1;
            end
          end
        end
        PM_SUBACT: begin
          if (sleep) begin
            if (cfg.ssel && !cfg.dtr && cfg.psel) begin
              nxt.mode = PM_WATCH;
            end else if (!cfg.ssel && cfg.lspd && cfg.psel) begin
              nxt.mode = PM_SUBSLEEP;
            end else if (cfg.ssel && cfg.dtr && !cfg.lspd && cfg.psel) begin
              nxt.mode    = PM_HIGH;
              nxt.div_clr = 1'b1;
            end else begin
              nxt.illegal = 1'b1;
            end
          end
        end
        PM_SUBSLEEP: if (irq) nxt.mode = PM_SUBACT;
        PM_WATCH:    if (irq && cfg.lspd) nxt.mode = PM_SUBACT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pm_clkgate.sv
module pm_clkgate
  import pm_pkg::*;
#(
  parameter int              NGRP     = 8,
  parameter logic [NGRP-1:0] SUB_KEEP = '0
) (
  input  pm_mode_e        mode,
  output logic [NGRP-1:0] clk_en,
  output logic            osc_en,
  output logic            sub_clk,
  output logic            halt
);
  logic full_run;
  logic slow_run;

  assign full_run = (mode == PM_HIGH);
  assign slow_run = (mode == PM_SUBACT) || (mode == PM_SUBSLEEP) || (mode == PM_WATCH);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign clk_en[g] = full_run | (SUB_KEEP[g] & slow_run);
  end

  assign osc_en  = full_run;
  assign sub_clk = slow_run;
  assign halt    = (mode == PM_SUBSLEEP) || (mode == PM_WATCH) || (mode == PM_HWSTBY);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pm_pkg::*;
#(
  parameter int NGRP        = 8,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             irq_req,
  input  logic             rst_pin_a,
  input  logic             rst_pin_b,
  input  logic             stby_n,
  input  logic             cfg_ssel,
  input  logic             cfg_dtr,
  input  logic             cfg_lspd,
  input  logic             cfg_psel,
  input  logic [DIV_W-1:0] cfg_div,
  output logic [2:0]       mode_o,
  output logic             cpu_sub_clk,
  output logic             cpu_halt,
  output logic [NGRP-1:0]  clk_en,
  output logic             osc_en,
  output logic             illegal_req,
  output logic             cfg_err,
  output logic             div_clr
);
  // Groups 0..3 (bus controller, timers, two watchdogs) run on the subclock.
  localparam logic [NGRP-1:0] SUB_KEEP = NGRP'(4'hF);

  logic     srst_n;
  pm_cfg_t  cfg;
  pm_dec_t  nxt;
  pm_mode_e mode_q;
  logic     mode_en;
  logic     ill_q, err_q, clr_q;

  assign cfg = '{ssel: cfg_ssel, dtr: cfg_dtr, lspd: cfg_lspd, psel: cfg_psel};

  pm_rstsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pm_next #(.DIV_W(DIV_W)) u_next (
    .cur     (mode_q),
    .sleep   (sleep_req),
    .irq     (irq_req),
    .cfg     (cfg),
    .div     (cfg_div),
    .rst_pin (rst_pin_a | rst_pin_b),
    .stby_n  (stby_n),
    .nxt     (nxt)
  );

  assign mode_en = (nxt.mode != mode_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mode_q <= PM_HIGH;
    else if (mode_en) mode_q <= nxt.mode;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ill_q <= 1'b0;
      err_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      ill_q <= nxt.illegal;
      err_q <= nxt.cfg_err;
      clr_q <= nxt.div_clr;
    end
  end

  pm_clkgate #(.NGRP(NGRP), .SUB_KEEP(SUB_KEEP)) u_gate (
    .mode    (mode_q),
    .clk_en  (clk_en),
    .osc_en  (osc_en),
    .sub_clk (cpu_sub_clk),
    .halt    (cpu_halt)
  );

  assign mode_o      = mode_q;
  assign illegal_req = ill_q;
  assign cfg_err     = err_q;
  assign div_clr     = clr_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NGRP  = 8,
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             srst_n,
  input logic             sleep_req,
  input logic             irq_req,
  input logic             rst_pin_a,
  input logic             rst_pin_b,
  input logic             stby_n,
  input logic             cfg_ssel,
  input logic             cfg_dtr,
  input logic             cfg_lspd,
  input logic             cfg_psel,
  input logic [DIV_W-1:0] cfg_div,
  input logic [2:0]       mode_o,
  input logic             cpu_sub_clk,
  input logic             cpu_halt,
  input logic [NGRP-1:0]  clk_en,
  input logic             osc_en,
  input logic             illegal_req,
  input logic             cfg_err,
  input logic             div_clr
);
  logic quiet;
  logic all_set;
  assign quiet   = stby_n && !rst_pin_a && !rst_pin_b;
  assign all_set = cfg_ssel && cfg_dtr && cfg_lspd && cfg_psel;

  p_stby_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !stby_n |=> mode_o == 3'd4);

  p_rstpin_r10: assert property (@(posedge clk) disable iff (!srst_n)
    stby_n && (rst_pin_a || rst_pin_b) |=> mode_o == 3'd0);

  p_enter_sub_r2: assert property (@(posedge clk) disable iff (!srst_n)
    quiet && mode_o == 3'd0 && sleep_req && all_set && cfg_div == '0 |=> mode_o == 3'd1);

  p_div_err_r3: assert property (@(posedge clk) disable iff (!srst_n)
    quiet && mode_o == 3'd0 && sleep_req && all_set && cfg_div != '0
    |=> cfg_err && mode_o == 3'd0);

  p_to_watch_r4: assert property (@(posedge clk) disable iff (!srst_n)
    quiet && mode_o == 3'd1 && sleep_req && cfg_ssel && !cfg_dtr && cfg_psel
    |=> mode_o == 3'd3);

  p_div_clr_r6: assert property (@(posedge clk) disable iff (!srst_n)
    div_clr |-> mode_o == 3'd0);

  p_subsleep_wake_r8: assert property (@(posedge clk) disable iff (!srst_n)
    quiet && mode_o == 3'd2 && irq_req |=> mode_o == 3'd1);

  p_illegal_src_r11: assert property (@(posedge clk) disable iff (!srst_n)
    illegal_req |-> $past(sleep_req));

  p_osc_r12: assert property (@(posedge clk) disable iff (!srst_n)
    osc_en |-> mode_o == 3'd0 && (&clk_en));

  p_subclk_r13: assert property (@(posedge clk) disable iff (!srst_n)
    mode_o == 3'd1 |-> cpu_sub_clk && !cpu_halt);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NGRP(NGRP), .DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .sleep_req   (sleep_req),
  .irq_req     (irq_req),
  .rst_pin_a   (rst_pin_a),
  .rst_pin_b   (rst_pin_b),
  .stby_n      (stby_n),
  .cfg_ssel    (cfg_ssel),
  .cfg_dtr     (cfg_dtr),
  .cfg_lspd    (cfg_lspd),
  .cfg_psel    (cfg_psel),
  .cfg_div     (cfg_div),
  .mode_o      (mode_o),
  .cpu_sub_clk (cpu_sub_clk),
  .cpu_halt    (cpu_halt),
  .clk_en      (clk_en),
  .osc_en      (osc_en),
  .illegal_req (illegal_req),
  .cfg_err     (cfg_err),
  .div_clr     (div_clr)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NGRP  = 8;
  localparam int DIV_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_req, irq_req, rst_pin_a, rst_pin_b, stby_n;
  logic cfg_ssel, cfg_dtr, cfg_lspd, cfg_psel;
  logic [DIV_W-1:0] cfg_div;
  logic [2:0] mode_o;
  logic cpu_sub_clk, cpu_halt, osc_en, illegal_req, cfg_err, div_clr;
  logic [NGRP-1:0] clk_en;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NGRP(NGRP), .DIV_W(DIV_W)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_req(irq_req),
    .rst_pin_a(rst_pin_a), .rst_pin_b(rst_pin_b), .stby_n(stby_n),
    .cfg_ssel(cfg_ssel), .cfg_dtr(cfg_dtr), .cfg_lspd(cfg_lspd), .cfg_psel(cfg_psel),
    .cfg_div(cfg_div), .mode_o(mode_o), .cpu_sub_clk(cpu_sub_clk), .cpu_halt(cpu_halt),
    .clk_en(clk_en), .osc_en(osc_en), .illegal_req(illegal_req), .cfg_err(cfg_err),
    .div_clr(div_clr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    sleep_req = 0; irq_req = 0; rst_pin_a = 0; rst_pin_b = 0; stby_n = 1;
  endtask

  task automatic set_cfg(input logic [3:0] c, input logic [DIV_W-1:0] d);
    {cfg_ssel, cfg_dtr, cfg_lspd, cfg_psel} = c;
    cfg_div = d;
  endtask

  // Bring the block to mode m through a reset pin and the documented transitions.
  task automatic goto_mode(input int m);
    idle();
    rst_pin_a = 1; tick(); rst_pin_a = 0;
    if (m == 4) begin
      stby_n = 0; tick(); stby_n = 1;
    end else if (m != 0) begin
      set_cfg(4'hF, '0); sleep_req = 1; tick(); sleep_req = 0;
      if (m == 2) begin set_cfg(4'b0011, '0); sleep_req = 1; tick(); sleep_req = 0; end
      if (m == 3) begin set_cfg(4'b1001, '0); sleep_req = 1; tick(); sleep_req = 0; end
    end
  endtask

  // Expected {mode, illegal, cfg_err, div_clr} after one edge, from the requirements.
  task automatic model(input int cur, input logic slp, input logic irq, input logic [3:0] c,
                       input int div, input logic rp, input logic sb,
                       output logic [5:0] res, output string tag);
    logic ss, dt, ls, ps;
    int nm; logic il, er, cl;
    {ss, dt, ls, ps} = c;
    nm = cur; il = 0; er = 0; cl = 0; tag = "R14";
    if (!sb) begin nm = 4; tag = "R9"; end
    else if (rp) begin nm = 0; tag = "R10"; end
    else if (cur == 4) tag = "R9";
    else if (cur == 0 && slp) begin
      if (c == 4'hF) begin
        if (div == 0) begin nm = 1; tag = "R2"; end else begin er = 1; tag = "R3"; end
      end else begin il = 1; tag = "R11"; end
    end else if (cur == 1 && slp) begin
      if (ss && !dt && ps) begin nm = 3; tag = "R4"; end
      else if (!ss && ls && ps) begin nm = 2; tag = "R5"; end
      else if (ss && dt && !ls && ps) begin nm = 0; cl = 1; tag = "R6"; end
      else begin il = 1; tag = "R11"; end
    end else if (cur == 2 && irq) begin nm = 1; tag = "R8"; end
    else if (cur == 3 && irq) begin tag = "R7"; if (ls) nm = 1; end
    res = {3'(nm), il, er, cl};
  endtask

  task automatic check_outputs(input int m);
    logic [NGRP-1:0] en_exp;
    en_exp = (m == 0) ? '1 : (m == 4) ? '0 : NGRP'(4'hF);
    check("R12 clk_en", 16'(clk_en), 16'(en_exp));
    check("R12 osc_en", 16'(osc_en), 16'(m == 0));
    check("R13 sub_clk", 16'(cpu_sub_clk), 16'(m >= 1 && m <= 3));
    check("R13 halt", 16'(cpu_halt), 16'(m >= 2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [5:0] exp;
    string tag;
    idle(); set_cfg(4'h0, '0);
    rst_n = 0;
    repeat (3) tick();
    check("R1 reset mode", 16'(mode_o), 16'd0);
    check("R1 reset pulses", 16'({illegal_req, cfg_err, div_clr}), 16'd0);
    check_outputs(0);
    rst_n = 1;
    repeat (3) tick();
    check("R1 after release", 16'(mode_o), 16'd0);

    // Outputs in every reachable mode.
    for (int m = 0; m < 5; m++) begin
      goto_mode(m);
      check("R1 mode reach", 16'(mode_o), 16'(m));
      check_outputs(m);
    end

    // Sleep strobe sweep: all modes, all 16 configurations, zero and nonzero divider.
    for (int m = 0; m < 5; m++)
      for (int c = 0; c < 16; c++)
        for (int d = 0; d < 2; d++) begin
          goto_mode(m);
          set_cfg(4'(c), DIV_W'(d * 5));
          model(m, 1'b1, 1'b0, 4'(c), d * 5, 1'b0, 1'b1, exp, tag);
          sleep_req = 1; tick(); sleep_req = 0;
          check(tag, 16'({mode_o, illegal_req, cfg_err, div_clr}), 16'(exp));
          tick();
          check({tag, " one-cycle pulse"}, 16'({illegal_req, cfg_err, div_clr}), 16'd0);
        end

    // Interrupt sweep over modes and low-speed-on.
    for (int m = 0; m < 5; m++)
      for (int l = 0; l < 2; l++) begin
        goto_mode(m);
        set_cfg({2'b00, 1'(l), 1'b0}, '0);
        model(m, 1'b0, 1'b1, {2'b00, 1'(l), 1'b0}, 0, 1'b0, 1'b1, exp, tag);
        irq_req = 1; tick(); irq_req = 0;
        check(tag, 16'({mode_o, illegal_req, cfg_err, div_clr}), 16'(exp));
      end

    // Standby pin and reset pins from every mode, including both at once.
    for (int m = 0; m < 5; m++) begin
      goto_mode(m);
      stby_n = 0; rst_pin_b = 1; sleep_req = 1; set_cfg(4'hF, '0); tick();
      idle();
      check("R9 standby priority", 16'(mode_o), 16'd4);
      check_outputs(4);
      goto_mode(m);
      rst_pin_b = 1; tick(); rst_pin_b = 0;
      check("R10 reset pin b", 16'(mode_o), 16'd0);
    end

    // Hardware standby exit needs a reset pin.
    goto_mode(4);
    repeat (3) tick();
    check("R9 stays", 16'(mode_o), 16'd4);
    rst_pin_a = 1; tick(); rst_pin_a = 0;
    check("R9 exit by reset", 16'(mode_o), 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule